// File: doc/BRIEF.md
# Receive FIFO with Interrupt Identification

This block is the receive-side character queue of a UART-style peripheral, together with the logic that tells the host why it is being interrupted. A deserializer delivers characters one at a time, each with an error flag. The host pops them in arrival order through a show-ahead read port. A software control byte turns queueing on or off, picks one of four receive thresholds, issues one-shot clears and selects a DMA mode.

Four interrupt sources feed a prioritizing encoder:

- receive line status (overrun or a flagged character),
- received data at or above the threshold,
- transmit holding register empty,
- modem status change.

Each source is gated by its own enable bit. The encoder produces an identification byte and an interrupt request line. With queueing disabled, the receiver behaves as a single holding register.

Top module: `rxq_top`

## Requirements
- R1: After reset, fifo_level is 0, overrun is 0, tx_clr is 0, irq is 0 and iid reads 8'h01.
- R2: With queueing enabled, up to 16 characters are held and read back in arrival order. host_rdata always shows the oldest character, and host_rd removes it. host_rd on an empty queue has no effect.
- R3: A control write with bit 1 set empties the receive queue by the next cycle, and it wins over an arrival in the same cycle. A control write with bit 2 set raises tx_clr for exactly one cycle and leaves the receive queue untouched. Neither bit is stored.
- R4: Control bit 0 enables queueing. While it is 0, capacity is one character. Any control write that changes bit 0 empties the receive queue.
- R5: A character that arrives while the queue is at capacity is discarded and sets overrun. overrun stays set until lsr_rd.
- R6: Control bits 7:6 select the receive threshold as 00=1, 01=4, 10=8 and 11=14 characters. The received-data cause is pending while fifo_level is at or above the threshold when queueing is enabled, and at or above 1 when it is disabled.
- R7: iid bit 0 is 1 when nothing is reported. Bits 2:1 carry the cause: 11 line status, 10 received data, 01 transmit holding empty, 00 modem status. Bits 7:3 are 0, and irq equals the inverse of iid bit 0.
- R8: The enable register (ien_wdata) uses bit 0 for received data, bit 1 for transmit empty, bit 2 for line status and bit 3 for modem status. Only enabled pending causes are reported, highest first in the order line status, received data, transmit empty, modem status.
- R9: The transmit-empty cause is set by thr_empty_evt. It is cleared by thr_wr, or by iid_rd in a cycle where iid reports code 01. An iid_rd while another cause is reported leaves it pending.
- R10: The line-status cause is pending while overrun is set or after a character flagged by rx_err has been accepted. lsr_rd clears both.
- R11: dma_mode follows control bit 3 of the last control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 4 | Interrupt enable bits |
| rx_valid | input | 1 | Character from deserializer |
| rx_data | input | 8 | Received character |
| rx_err | input | 1 | Character carries a line error |
| host_rd | input | 1 | Pop the oldest character |
| host_rdata | output | 8 | Oldest character (show-ahead) |
| lsr_rd | input | 1 | Host read of line status; clears error causes |
| thr_empty_evt | input | 1 | Transmit holding register became empty |
| thr_wr | input | 1 | Host wrote the transmit buffer |
| iid_rd | input | 1 | Host read of the identification byte |
| modem_chg | input | 1 | Modem status change pending (level) |
| fifo_level | output | 5 | Characters held |
| data_ready | output | 1 | At least one character held |
| overrun | output | 1 | Sticky overrun flag |
| iid | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |
| dma_mode | output | 1 | DMA mode select |
| tx_clr | output | 1 | One-cycle transmit queue clear |

## Verification
The hardest state to reach from the ports is any chosen combination of the four pending causes under any enable mask. Received data and line status both come from the same arrival path, so a flagged character alone would also raise received data. The stimulus therefore sets the threshold to 14. It raises line status with a single flagged character and raises received data only by pushing fourteen more. All 16 pending sets are then crossed with all 16 enable masks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    CAUSE_MODEM  = 2'b00,
    CAUSE_THR    = 2'b01,
    CAUSE_RXDATA = 2'b10,
    CAUSE_LINE   = 2'b11
  } cause_e;

  // control byte field positions
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_RXC_BIT = 1;
  localparam int CTL_TXC_BIT = 2;
  localparam int CTL_DMA_BIT = 3;
  localparam int CTL_TRG_LSB = 6;

  // source index within the enable / pending vectors
  localparam int SRC_RXDATA = 0;
  localparam int SRC_THR    = 1;
  localparam int SRC_LINE   = 2;
  localparam int SRC_MODEM  = 3;

  typedef struct packed {
    logic [1:0] trig;
    logic       dma;
    logic       en;
  } ctl_s;

  function automatic logic [4:0] trig_chars(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // returns {cause, none}
  function automatic logic [2:0] iid_pick(input logic [3:0] act);
    if (act[SRC_LINE])        return {CAUSE_LINE, 1'b0};
    else if (act[SRC_RXDATA]) return {CAUSE_RXDATA, 1'b0};
    else if (act[SRC_THR])    return {CAUSE_THR, 1'b0};
    else if (act[SRC_MODEM])  return {CAUSE_MODEM, 1'b0};
    else                      return 3'b001;
  endfunction

endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic       fifo_en,
  output logic       dma_mode,
  output logic [1:0] trig_sel,
  output logic       rx_flush,
  output logic       tx_clr
);

  ctl_s ctl_q;
  logic tx_clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      tx_clr_q <= 1'b0;
    end else begin
      tx_clr_q <= ctl_wr && ctl_wdata[CTL_TXC_BIT];
      if (ctl_wr) begin
        ctl_q.en   <= ctl_wdata[CTL_EN_BIT];
        ctl_q.dma  <= ctl_wdata[CTL_DMA_BIT];
        ctl_q.trig <= ctl_wdata[CTL_TRG_LSB +: 2];
      end
    end
  end

  assign rx_flush = ctl_wr &&
                    (ctl_wdata[CTL_RXC_BIT] || (ctl_wdata[CTL_EN_BIT] != ctl_q.en));
  assign fifo_en  = ctl_q.en;
  assign dma_mode = ctl_q.dma;
  assign trig_sel = ctl_q.trig;
  assign tx_clr   = tx_clr_q;

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  output logic [DW-1:0] head,
  output logic [CW-1:0] level,
  output logic          accept,
  output logic          overflow
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, take;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level >= cap);
  assign accept   = push && !full && !flush;
  assign overflow = push && full && !flush;
  assign take     = pop && (level != '0) && !flush;

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (accept) wptr <= bump(wptr);
      if (take)   rptr <= bump(rptr);
      case ({accept, take})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head = mem[rptr];

endmodule

// File: rtl/rxq_intid.sv
module rxq_intid
  import rxq_pkg::*;
(
  input  logic [3:0] pend,
  input  logic [3:0] ien,
  output logic [7:0] iid,
  output logic       none,
  output cause_e     cause
);

  logic [2:0] pick;

  assign pick  = iid_pick(pend & ien);
  assign cause = cause_e'(pick[2:1]);
  assign none  = pick[0];
  assign iid   = {5'b00000, pick};

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          ien_wr,
  input  logic [3:0]    ien_wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_err,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          lsr_rd,
  input  logic          thr_empty_evt,
  input  logic          thr_wr,
  input  logic          iid_rd,
  input  logic          modem_chg,
  output logic [CW-1:0] fifo_level,
  output logic          data_ready,
  output logic          overrun,
  output logic [7:0]    iid,
  output logic          irq,
  output logic          dma_mode,
  output logic          tx_clr
);

  logic          fifo_en, rx_flush;
  logic [1:0]    trig_sel;
  logic [CW-1:0] fifo_cap, trig_cnt;
  logic          evt_accept, evt_overrun, evt_err_accept, thr_rd_ack;
  logic          ovr_q, err_q, thr_q, ls_pend, rd_pend, none;
  logic [3:0]    ien_q, pend;
  cause_e        cause;

  rxq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .fifo_en(fifo_en), .dma_mode(dma_mode), .trig_sel(trig_sel),
    .rx_flush(rx_flush), .tx_clr(tx_clr)
  );

  assign fifo_cap = fifo_en ? CW'(DEPTH) : CW'(1);
  assign trig_cnt = fifo_en ? CW'(trig_chars(trig_sel)) : CW'(1);

  rxq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(rx_data),
    .pop(host_rd), .flush(rx_flush), .cap(fifo_cap), .head(host_rdata),
    .level(fifo_level), .accept(evt_accept), .overflow(evt_overrun)
  );

  assign evt_err_accept = evt_accept && rx_err;
  assign thr_rd_ack     = iid_rd && !none && (cause == CAUSE_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      err_q <= 1'b0;
      thr_q <= 1'b0;
      ien_q <= '0;
    end else begin
      if (evt_overrun)         ovr_q <= 1'b1;
      else if (lsr_rd)         ovr_q <= 1'b0;
      if (evt_err_accept)      err_q <= 1'b1;
      else if (lsr_rd)         err_q <= 1'b0;
      if (thr_empty_evt)       thr_q <= 1'b1;
      else if (thr_wr || thr_rd_ack) thr_q <= 1'b0;
      if (ien_wr)              ien_q <= ien_wdata;
    end
  end

  assign ls_pend = ovr_q | err_q;
  assign rd_pend = (fifo_level >= trig_cnt);

  always_comb begin
    pend             = '0;
    pend[SRC_RXDATA] = rd_pend;
    pend[SRC_THR]    = thr_q;
    pend[SRC_LINE]   = ls_pend;
    pend[SRC_MODEM]  = modem_chg;
  end

  rxq_intid u_intid (
    .pend(pend), .ien(ien_q), .iid(iid), .none(none), .cause(cause)
  );

  assign irq        = !none;
  assign overrun    = ovr_q;
  assign data_ready = (fifo_level != '0);

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [7:0]    ctl_wdata,
  input logic          rx_valid,
  input logic          lsr_rd,
  input logic          thr_wr,
  input logic          thr_empty_evt,
  input logic [CW-1:0] fifo_level,
  input logic [CW-1:0] fifo_cap,
  input logic          overrun,
  input logic [7:0]    iid,
  input logic [3:0]    ien_q,
  input logic          thr_q,
  input logic          ls_pend
);

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[1] |=> fifo_level == '0); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= fifo_cap); // R2

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level == '0 && !rx_valid |=> fifo_level == '0); // R2

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !ctl_wr && !lsr_rd && fifo_level == fifo_cap |=> overrun); // R5

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ien_q == 4'h0 |-> iid[0]); // R8

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ls_pend && ien_q[2] |-> iid[2:0] == 3'b110); // R7

  AST_THR_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr && !thr_empty_evt |=> !thr_q); // R9

endmodule

bind rxq_top rxq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .rx_valid(rx_valid), .lsr_rd(lsr_rd), .thr_wr(thr_wr),
  .thr_empty_evt(thr_empty_evt), .fifo_level(fifo_level),
  .fifo_cap(fifo_cap), .overrun(overrun), .iid(iid), .ien_q(ien_q),
  .thr_q(thr_q), .ls_pend(ls_pend)
);

// File: tb/test_rxq_top.sv
`timescale 1ns/1ps
module test_rxq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 0, ien_wr = 0, rx_valid = 0, rx_err = 0, host_rd = 0;
  logic       lsr_rd = 0, thr_empty_evt = 0, thr_wr = 0, iid_rd = 0, modem_chg = 0;
  logic [7:0] ctl_wdata = 0, rx_data = 0;
  logic [3:0] ien_wdata = 0;
  logic [7:0] host_rdata, iid;
  logic [4:0] fifo_level;
  logic       data_ready, overrun, irq, dma_mode, tx_clr;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  rxq_top i_rxq_top (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_err(rx_err), .host_rd(host_rd),
    .host_rdata(host_rdata), .lsr_rd(lsr_rd), .thr_empty_evt(thr_empty_evt),
    .thr_wr(thr_wr), .iid_rd(iid_rd), .modem_chg(modem_chg),
    .fifo_level(fifo_level), .data_ready(data_ready), .overrun(overrun),
    .iid(iid), .irq(irq), .dma_mode(dma_mode), .tx_clr(tx_clr)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int trig_of(input int s);
    return (s == 0) ? 1 : (s == 3) ? 14 : 4 * s;
  endfunction

  // expected identification byte from the active (pending & enabled) mask
  function automatic int exp_iid(input logic [3:0] act);
    int rank[4] = '{2, 0, 1, 3};
    int code[4] = '{3, 2, 1, 0};
    for (int k = 0; k < 4; k++)
      if (act[rank[k]]) return code[k] * 2;
    return 1;
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; @(negedge clk); ctl_wr = 0;
  endtask
  task automatic wr_ien(input logic [3:0] v);
    ien_wr = 1; ien_wdata = v; @(negedge clk); ien_wr = 0;
  endtask
  task automatic push(input logic [7:0] d, input logic e);
    rx_valid = 1; rx_data = d; rx_err = e; @(negedge clk); rx_valid = 0; rx_err = 0;
  endtask
  task automatic pop();
    host_rd = 1; @(negedge clk); host_rd = 0;
  endtask
  task automatic lsr_read();
    lsr_rd = 1; @(negedge clk); lsr_rd = 0;
  endtask
  task automatic thr_event();
    thr_empty_evt = 1; @(negedge clk); thr_empty_evt = 0;
  endtask
  task automatic thr_write();
    thr_wr = 1; @(negedge clk); thr_wr = 0;
  endtask
  task automatic iid_read();
    iid_rd = 1; @(negedge clk); iid_rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fifo_level, 0, "R1 level");
    chk(overrun, 0, "R1 overrun");
    chk(tx_clr, 0, "R1 tx_clr");
    chk(irq, 0, "R1 irq");
    chk(iid, 8'h01, "R1 iid");
    rst_n = 1;
    @(negedge clk);

    // R2 R5 R6: trigger sweep over all four thresholds
    for (int s = 0; s < 4; s++) begin
      wr_ctl(8'(s << 6) | 8'h03);
      wr_ien(4'h1);
      for (int i = 0; i < 16; i++) begin
        push(8'(s * 16 + i), 1'b0);
        chk(fifo_level, i + 1, "R2 level");
        chk(irq, int'(i + 1 >= trig_of(s)), "R6 irq at threshold");
        chk(iid, (i + 1 >= trig_of(s)) ? 8'h04 : 8'h01, "R6 iid");
      end
      push(8'hEE, 1'b0);
      chk(fifo_level, 16, "R5 level when full");
      chk(overrun, 1, "R5 overrun set");
      chk(iid, 8'h04, "R8 line masked");
      wr_ien(4'h5);
      chk(iid, 8'h06, "R10 overrun raises line status");
      for (int i = 0; i < 16; i++) begin
        chk(host_rdata, s * 16 + i, "R2 order");
        pop();
      end
      pop();
      chk(fifo_level, 0, "R2 pop on empty");
      chk(overrun, 1, "R5 overrun sticky");
      lsr_read();
      chk(overrun, 0, "R5 lsr_rd clears");
    end

    // R3 flush wins over a simultaneous arrival
    wr_ctl(8'h01);
    push(8'h11, 0); push(8'h12, 0); push(8'h13, 0);
    ctl_wr = 1; ctl_wdata = 8'h03; rx_valid = 1; rx_data = 8'h99;
    @(negedge clk); ctl_wr = 0; rx_valid = 0;
    chk(fifo_level, 0, "R3 flush precedence");
    push(8'h21, 0); push(8'h22, 0);
    wr_ctl(8'h05);
    chk(tx_clr, 1, "R3 tx_clr pulse");
    chk(fifo_level, 2, "R3 tx clear keeps rx");
    @(negedge clk);
    chk(tx_clr, 0, "R3 tx_clr one cycle");
    wr_ctl(8'h09);
    chk(dma_mode, 1, "R11 dma set");
    chk(fifo_level, 2, "R4 no flush without enable change");
    wr_ctl(8'h01);
    chk(dma_mode, 0, "R11 dma clear");

    // R4 disabled mode: single holding register
    wr_ctl(8'h00);
    chk(fifo_level, 0, "R4 enable change flushes");
    wr_ctl(8'hC0);
    push(8'h5A, 0);
    chk(fifo_level, 1, "R4 one held");
    wr_ien(4'h1);
    chk(iid, 8'h04, "R6 disabled threshold is one");
    push(8'h5B, 0);
    chk(fifo_level, 1, "R4 capacity one");
    chk(overrun, 1, "R4 overrun in holding mode");
    chk(host_rdata, 8'h5A, "R4 first kept");
    lsr_read();

    // R9 transmit-empty cause
    wr_ien(4'h2);
    thr_event();
    chk(iid, 8'h02, "R9 thr reported");
    iid_read();
    chk(iid, 8'h01, "R9 iid read clears");
    thr_event();
    wr_ien(4'h3);
    chk(iid, 8'h04, "R8 data above thr");
    iid_read();
    wr_ien(4'h2);
    chk(iid, 8'h02, "R9 not cleared when unreported");
    thr_write();
    chk(iid, 8'h01, "R9 thr_wr clears");

    // R10 line status from a flagged character
    pop();
    wr_ctl(8'h03);
    wr_ien(4'h4);
    push(8'h33, 1);
    chk(iid, 8'h06, "R10 flagged char");
    chk(irq, 1, "R7 irq follows");
    lsr_read();
    chk(iid, 8'h01, "R10 lsr_rd clears");
    chk(irq, 0, "R7 irq low");

    // R7 R8 every pending set crossed with every enable mask
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        modem_chg = 0;
        wr_ien(4'h0);
        wr_ctl(8'hC3);
        lsr_read();
        thr_write();
        if (p[2]) push(8'hA5, 1'b1);
        if (p[0]) for (int k = 0; k < 14; k++) push(8'(k), 1'b0);
        if (p[1]) thr_event();
        modem_chg = p[3];
        wr_ien(4'(e));
        chk(iid, exp_iid(4'(p & e)), "R8 priority iid");
        chk(irq, int'((p & e) != 0), "R7 irq");
      end
    end
    modem_chg = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule